// File: doc/BRIEF.md
# Motion-Gated Frame Forwarding Filter

This block sits between a foreground mask generator and a downstream detector. Each input beat carries one original pixel and the foreground bit computed for that same pixel, together with a start-of-frame flag and an end-of-line flag. While a frame arrives, the block writes the original pixels into an on-chip frame buffer and counts the beats whose foreground bit is set. On the final pixel of the frame it compares that count against a threshold. If the count is strictly above the threshold, the buffered frame is streamed out whole. Otherwise the frame is discarded and nothing is emitted.

The frame geometry is fixed by parameters (pixels per line and lines per frame). A frame begins on a beat flagged start-of-frame and ends on the end-of-line beat of its last line. Per-line markers on the output are regenerated from that geometry. A one-cycle status pulse reports the count and the pass or drop verdict for every completed frame. A parameter selects one or two frame buffers. With one buffer, input is held off while a passed frame drains. With two buffers, a new frame can be collected while the previous one streams out.

Top module: `motion_frame_gate`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` and `stat_valid` are 0.
- R2: The foreground count restarts on every accepted beat with `in_sof`=1. It counts each accepted in-frame beat with `in_fg`=1. It is reported on `stat_count` in the cycle right after the frame's final beat is accepted.
- R3: A frame passes only when its count is strictly greater than the threshold. A count equal to the threshold drops the frame. `stat_pass` carries the verdict (1 = forward).
- R4: The threshold is captured from `thr_in` on the start-of-frame beat. Changes to `thr_in` later in the frame do not affect that frame's verdict.
- R5: A passed frame is emitted in arrival order as LINE_PIX*FRAME_LINES beats on consecutive cycles. `out_sof`=1 marks the first beat. `out_eol`=1 marks every beat whose index modulo LINE_PIX equals LINE_PIX-1.
- R6: A dropped frame produces no output beats.
- R7: Accepted beats that arrive while no frame is open (no preceding `in_sof`) produce neither output beats nor a status pulse.
- R8: An `in_sof` beat in the middle of a frame abandons the partial frame. Counting and buffering restart from that beat, and only one status pulse results.
- R9: With NBUF=1, `in_ready` is 0 from the status cycle of a passed frame up to the cycle that frame's last output beat appears. It is 1 from that cycle on.
- R10: With NBUF=2, `in_ready` is 0 only while two passed frames are waiting or streaming.
- R11: `stat_valid` is a one-cycle pulse, given exactly once for each completed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_sof | input | 1 | Beat is the first pixel of a frame |
| in_eol | input | 1 | Beat is the last pixel of a line |
| in_pix | input | PIX_W | Original pixel value |
| in_fg | input | 1 | Foreground bit for this pixel |
| thr_in | input | CNT_W | Foreground threshold, captured at start of frame |
| out_valid | output | 1 | Output beat present |
| out_sof | output | 1 | First beat of a forwarded frame |
| out_eol | output | 1 | Last beat of a line in a forwarded frame |
| out_pix | output | PIX_W | Forwarded pixel value |
| stat_valid | output | 1 | One-cycle verdict pulse |
| stat_pass | output | 1 | 1 when the frame is forwarded |
| stat_count | output | CNT_W | Foreground count of the frame |

## Verification
The bench builds two copies of the block with an 8-pixel by 4-line frame (32 buffered pixels, 6-bit count and threshold). One copy uses NBUF=1 and the other NBUF=2. The small frame lets directed cases reach both count extremes (zero and all 32 pixels) and the counts just at and just above the threshold, within a few dozen cycles per frame. Having both buffer settings side by side lets every cycle's `in_ready` be compared with the number of pending passed frames. That covers both the stall-while-draining behaviour and the collect-while-draining behaviour.

// File: rtl/mgf_pkg.sv
package mgf_pkg;

  // Verdict rule: strictly above the threshold forwards the frame.
  function automatic logic fg_exceeds(input int unsigned cnt, input int unsigned thr);
    return cnt > thr;
  endfunction

  // Saturating add used by the foreground counter.
  function automatic int unsigned sat_add(input int unsigned a, input int unsigned b,
                                          input int unsigned lim);
    int unsigned s;
    s = a + b;
    return (s > lim) ? lim : s;
  endfunction

  // Position of a buffer address within its line.
  function automatic logic is_line_end(input int unsigned addr, input int unsigned line_pix);
    return (addr % line_pix) == (line_pix - 1);
  endfunction

  function automatic logic is_last_line(input int unsigned line, input int unsigned lines);
    return line == (lines - 1);
  endfunction

  // Flat memory index of (bank, address).
  function automatic int unsigned mem_index(input int unsigned bank, input int unsigned addr,
                                            input int unsigned depth);
    return bank * depth + addr;
  endfunction

endpackage

// File: rtl/mgf_frame_tracker.sv
module mgf_frame_tracker #(
  parameter int LINE_PIX    = 8,
  parameter int FRAME_LINES = 4,
  parameter int ADDR_W      = 5,
  parameter int LINE_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_fire,
  input  logic              beat_sof,
  input  logic              beat_eol,
  output logic              beat_in_frame,
  output logic              frame_start,
  output logic              frame_end,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr
);
  import mgf_pkg::*;

  localparam int DEPTH = LINE_PIX * FRAME_LINES;
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W + 1)'(DEPTH);

  logic              in_frame_q;
  logic [ADDR_W:0]   addr_q;
  logic [LINE_W-1:0] line_q;
  logic [ADDR_W:0]   addr_base;
  logic [LINE_W-1:0] line_base;
  logic              on_last_line;

  assign frame_start   = beat_fire & beat_sof;
  assign beat_in_frame = beat_fire & (beat_sof | in_frame_q);
  assign addr_base     = frame_start ? '0 : addr_q;
  assign line_base     = frame_start ? '0 : line_q;
  assign on_last_line  = is_last_line(32'(line_base), FRAME_LINES);
  assign frame_end     = beat_in_frame & beat_eol & on_last_line;
  assign wr_en         = beat_in_frame & (addr_base < DEPTH_V);
  assign wr_addr       = addr_base[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      addr_q     <= '0;
      line_q     <= '0;
    end else if (beat_in_frame) begin
      in_frame_q <= !frame_end;
      addr_q     <= (addr_base < DEPTH_V) ? addr_base + (ADDR_W + 1)'(1) : addr_base;
      if (beat_eol && !on_last_line) line_q <= line_base + LINE_W'(1);
      else if (frame_end)            line_q <= '0;
      else                           line_q <= line_base;
    end
  end

  // R8: a start beat always reopens a fresh frame at buffer address one.
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !frame_end |=> in_frame_q && (addr_q == (ADDR_W + 1)'(1)));

  // R2: an open frame never reports a line index beyond the frame.
  p_line_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_frame_q |-> (32'(line_q) < FRAME_LINES));

endmodule

// File: rtl/mgf_fg_counter.sv
module mgf_fg_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_in_frame,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             fg,
  input  logic [CNT_W-1:0] thr_in,
  output logic             pass_evt,
  output logic             stat_valid,
  output logic             stat_pass,
  output logic [CNT_W-1:0] stat_count
);
  import mgf_pkg::*;

  localparam int unsigned CNT_MAX = (2 ** CNT_W) - 1;

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] thr_q;
  logic [CNT_W-1:0] count_base;
  logic [CNT_W-1:0] count_next;
  logic [CNT_W-1:0] thr_eff;

  assign count_base = frame_start ? '0 : count_q;
  assign count_next = CNT_W'(sat_add(32'(count_base), 32'(fg), CNT_MAX));
  assign thr_eff    = frame_start ? thr_in : thr_q;
  assign pass_evt   = frame_end & fg_exceeds(32'(count_next), 32'(thr_eff));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q    <= '0;
      thr_q      <= '0;
      stat_valid <= 1'b0;
      stat_pass  <= 1'b0;
      stat_count <= '0;
    end else begin
      if (beat_in_frame) count_q <= count_next;
      if (frame_start)   thr_q   <= thr_in;
      stat_valid <= frame_end;
      stat_pass  <= pass_evt;
      if (frame_end) stat_count <= count_next;
    end
  end

  // R11: the verdict pulse lasts a single cycle.
  p_status_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);

  // R3: reported verdict agrees with the strict comparison on the held threshold.
  p_strict_compare_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_pass == (stat_count > thr_q)));

  // R4: the captured threshold moves only on a start beat.
  p_thr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(thr_q));

  // R2: a start beat leaves the count holding just its own foreground bit.
  p_count_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (count_q == CNT_W'($past(fg))));

endmodule

// File: rtl/mgf_frame_store.sv
module mgf_frame_store #(
  parameter int PIX_W  = 8,
  parameter int NBUF   = 2,
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic              wbank,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [PIX_W-1:0]  wdata,
  input  logic              rbank,
  input  logic [ADDR_W-1:0] raddr,
  output logic [PIX_W-1:0]  rdata
);
  import mgf_pkg::*;

  localparam int WORDS  = NBUF * DEPTH;
  localparam int MEM_AW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [PIX_W-1:0]  mem [WORDS];
  logic [MEM_AW-1:0] widx;
  logic [MEM_AW-1:0] ridx;

  assign widx  = MEM_AW'(mem_index(32'(wbank), 32'(waddr), DEPTH));
  assign ridx  = MEM_AW'(mem_index(32'(rbank), 32'(raddr), DEPTH));
  assign rdata = mem[ridx];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

endmodule

// File: rtl/mgf_frame_reader.sv
module mgf_frame_reader #(
  parameter int PIX_W    = 8,
  parameter int LINE_PIX = 8,
  parameter int DEPTH    = 32,
  parameter int ADDR_W   = 5,
  parameter int NBUF     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        full_vec,
  input  logic [PIX_W-1:0]  rdata,
  output logic              rbank,
  output logic [ADDR_W-1:0] raddr,
  output logic              done_evt,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eol,
  output logic [PIX_W-1:0]  out_pix
);
  import mgf_pkg::*;

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic rd_active_q;
  logic start_evt;
  logic next_bank;

  assign start_evt = !rd_active_q && full_vec[rbank];
  assign done_evt  = rd_active_q && (raddr == LAST_ADDR);
  assign next_bank = (NBUF == 2) ? ~rbank : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_active_q <= 1'b0;
      raddr       <= '0;
      rbank       <= 1'b0;
    end else if (start_evt) begin
      rd_active_q <= 1'b1;
      raddr       <= '0;
    end else if (done_evt) begin
      rd_active_q <= 1'b0;
      raddr       <= '0;
      rbank       <= next_bank;
    end else if (rd_active_q) begin
      raddr <= raddr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= rd_active_q;
      out_sof   <= rd_active_q && (raddr == '0);
      out_eol   <= rd_active_q && is_line_end(32'(raddr), LINE_PIX);
      out_pix   <= rd_active_q ? rdata : '0;
    end
  end

  // R5: only a filled buffer is ever read out.
  p_read_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active_q |-> full_vec[rbank]);

  // R5: beats after the first of a frame follow on back-to-back cycles.
  p_out_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sof |-> $past(out_valid));

endmodule

// File: rtl/motion_frame_gate.sv
module motion_frame_gate #(
  parameter int PIX_W       = 8,
  parameter int LINE_PIX    = 8,
  parameter int FRAME_LINES = 4,
  parameter int NBUF        = 2,
  localparam int DEPTH      = LINE_PIX * FRAME_LINES,
  localparam int ADDR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int LINE_W     = (FRAME_LINES > 1) ? $clog2(FRAME_LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sof,
  input  logic             in_eol,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_fg,
  input  logic [CNT_W-1:0] thr_in,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eol,
  output logic [PIX_W-1:0] out_pix,
  output logic             stat_valid,
  output logic             stat_pass,
  output logic [CNT_W-1:0] stat_count
);

  logic              beat_fire;
  logic              beat_in_frame;
  logic              frame_start;
  logic              frame_end;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic              pass_evt;
  logic              done_evt;
  logic              rbank;
  logic [ADDR_W-1:0] raddr;
  logic [PIX_W-1:0]  rdata;
  logic              wr_bank;
  logic [1:0]        full_q;

  assign beat_fire = in_valid & in_ready;
  assign in_ready  = !full_q[wr_bank];

  mgf_frame_tracker #(
    .LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)
  ) u_tracker (
    .clk(clk), .rst_n(rst_n), .beat_fire(beat_fire), .beat_sof(in_sof), .beat_eol(in_eol),
    .beat_in_frame(beat_in_frame), .frame_start(frame_start), .frame_end(frame_end),
    .wr_en(wr_en), .wr_addr(wr_addr)
  );

  mgf_fg_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .beat_in_frame(beat_in_frame), .frame_start(frame_start),
    .frame_end(frame_end), .fg(in_fg), .thr_in(thr_in), .pass_evt(pass_evt),
    .stat_valid(stat_valid), .stat_pass(stat_pass), .stat_count(stat_count)
  );

  mgf_frame_store #(.PIX_W(PIX_W), .NBUF(NBUF), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we(wr_en), .wbank(wr_bank), .waddr(wr_addr), .wdata(in_pix),
    .rbank(rbank), .raddr(raddr), .rdata(rdata)
  );

  mgf_frame_reader #(
    .PIX_W(PIX_W), .LINE_PIX(LINE_PIX), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .NBUF(NBUF)
  ) u_reader (
    .clk(clk), .rst_n(rst_n), .full_vec(full_q), .rdata(rdata), .rbank(rbank),
    .raddr(raddr), .done_evt(done_evt), .out_valid(out_valid), .out_sof(out_sof),
    .out_eol(out_eol), .out_pix(out_pix)
  );

  // Buffer ownership: set by a passing verdict, cleared when the reader finishes.
  for (genvar b = 0; b < 2; b++) begin : g_full
    always_ff @(posedge clk) begin
      if (!rst_n)                                  full_q[b] <= 1'b0;
      else if (pass_evt && (wr_bank == 1'(b)))     full_q[b] <= 1'b1;
      else if (done_evt && (rbank == 1'(b)))       full_q[b] <= 1'b0;
    end
  end

  if (NBUF == 2) begin : g_dbl
    logic wr_bank_q;
    always_ff @(posedge clk) begin
      if (!rst_n)        wr_bank_q <= 1'b0;
      else if (pass_evt) wr_bank_q <= ~wr_bank_q;
    end
    assign wr_bank = wr_bank_q;

    // R10: with both buffers free, a passing frame leaves input open.
    p_dbl_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid && stat_pass && $past(full_q == 2'b00) |-> in_ready);
  end else begin : g_sgl
    assign wr_bank = 1'b0;

    // R9: a passing frame closes the input while it drains.
    p_sgl_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid && stat_pass |-> !in_ready);
  end

  // R6: a buffer becomes owned by the reader only through a passing verdict.
  p_fill_on_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(full_q & ~$past(full_q))) |-> stat_valid && stat_pass);

endmodule

// File: tb/motion_frame_gate_harness.sv
module motion_frame_gate_harness #(
  parameter int          NBUF = 1,
  parameter int unsigned SEED = 1
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_checks,
  output int   n_errors,
  output logic done
);
  localparam int PIX_W = 8;
  localparam int LP    = 8;
  localparam int FL    = 4;
  localparam int DEPTH = LP * FL;
  localparam int CW    = 6;

  logic             in_valid, in_ready, in_sof, in_eol, in_fg;
  logic [PIX_W-1:0] in_pix;
  logic [CW-1:0]    thr_in;
  logic             out_valid, out_sof, out_eol;
  logic [PIX_W-1:0] out_pix;
  logic             stat_valid, stat_pass;
  logic [CW-1:0]    stat_count;

  motion_frame_gate #(.PIX_W(PIX_W), .LINE_PIX(LP), .FRAME_LINES(FL), .NBUF(NBUF))
  u_motion_frame_gate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
    .in_eol(in_eol), .in_pix(in_pix), .in_fg(in_fg), .thr_in(thr_in),
    .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_pix(out_pix),
    .stat_valid(stat_valid), .stat_pass(stat_pass), .stat_count(stat_count)
  );

  // Reference model state
  int exp_q[$];
  int frm_buf[$];
  bit m_in_frame;
  int m_line, m_cnt, m_thr;
  bit stat_due;
  int stat_cnt_e;
  bit stat_pass_e;
  int outstanding, out_pos, beats_seen, pulses_seen;

  function automatic bit ref_pass(int cnt, int thr);
    return cnt > thr;
  endfunction

  function automatic int ref_beat(int idx, int pix);
    return pix | ((idx == 0) ? 256 : 0) | (((idx % LP) == LP - 1) ? 512 : 0);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s (NBUF=%0d): actual %0d expected %0d", tag, NBUF, act, exp);
    end
  endtask

  task automatic model_accept(input bit sof, input bit eol, input int pix, input bit fg);
    if (sof) begin
      m_in_frame = 1; m_line = 0; m_cnt = 0; m_thr = int'(thr_in);
      frm_buf.delete();
    end
    if (m_in_frame) begin
      frm_buf.push_back(pix);
      m_cnt += int'(fg);
      if (eol) begin
        if (m_line == FL - 1) begin
          stat_due    = 1;
          stat_cnt_e  = m_cnt;
          stat_pass_e = ref_pass(m_cnt, m_thr);
          if (stat_pass_e)
            for (int i = 0; i < DEPTH; i++) exp_q.push_back(ref_beat(i, frm_buf[i]));
          m_in_frame = 0;
        end else m_line++;
      end
    end
  endtask

  task automatic step();
    bit last;
    int got, e;
    @(negedge clk);
    if (stat_due) begin
      chk(stat_valid == 1'b1, "R11 status pulse missing", int'(stat_valid), 1);
      chk(int'(stat_count) == stat_cnt_e, "R2 foreground count", int'(stat_count), stat_cnt_e);
      chk(stat_pass == stat_pass_e, "R3 pass verdict", int'(stat_pass), int'(stat_pass_e));
      stat_due = 0;
    end else begin
      chk(stat_valid == 1'b0, "R11 spurious status pulse", int'(stat_valid), 0);
    end
    if (stat_valid) pulses_seen++;
    last = 0;
    if (out_valid) begin
      beats_seen++;
      got = int'(out_pix) | (out_sof ? 256 : 0) | (out_eol ? 512 : 0);
      if (exp_q.size() == 0) chk(0, "R6 unexpected output beat", got, -1);
      else begin
        e = exp_q.pop_front();
        chk(got == e, "R5 output beat", got, e);
      end
      last = (out_pos == DEPTH - 1);
      out_pos = (out_pos + 1) % DEPTH;
    end else if (out_pos != 0) begin
      chk(0, "R5 gap inside forwarded frame", 0, 1);
    end
    if (stat_valid && stat_pass) outstanding++;
    if (last) outstanding--;
    if (NBUF == 1)
      chk(in_ready == (outstanding == 0), "R9 single-buffer ready", int'(in_ready),
          int'(outstanding == 0));
    else
      chk(in_ready == (outstanding < 2), "R10 double-buffer ready", int'(in_ready),
          int'(outstanding < 2));
  endtask

  task automatic idle(input int n);
    in_valid = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drive(input bit sof, input bit eol, input int pix, input bit fg);
    in_sof = sof; in_eol = eol; in_pix = PIX_W'(pix); in_fg = fg; in_valid = 1;
    while (1) begin
      if (in_ready) begin
        model_accept(sof, eol, pix, fg);
        step();
        break;
      end
      step();
    end
    in_valid = 0;
  endtask

  // mode 0: exactly k foreground pixels (scattered); mode 1: k percent density
  task automatic send_frame(input int thr, input int k, input int mode, input bit gaps,
                            input int thr_late);
    bit fg;
    for (int idx = 0; idx < DEPTH; idx++) begin
      if (gaps && ($urandom % 4 == 0)) idle(1 + $urandom % 3);
      fg = (mode == 0) ? (((idx * 7) % DEPTH) < k) : (($urandom % 100) < k);
      if (idx == 0) thr_in = CW'(thr);
      drive(idx == 0, (idx % LP) == LP - 1, int'($urandom % 256), fg);
      if (idx == 0 && thr_late >= 0) thr_in = CW'(thr_late);
    end
  endtask

  task automatic directed(input int thr, input int k);
    int b0;
    b0 = beats_seen;
    send_frame(thr, k, 0, 0, -1);
    idle(90);
    if (k > thr) chk(beats_seen == b0 + DEPTH, "R5 whole frame forwarded", beats_seen - b0, DEPTH);
    else chk(beats_seen == b0, "R6 dropped frame emitted beats", beats_seen - b0, 0);
  endtask

  initial begin
    int b0, p0, guard;
    n_checks = 0; n_errors = 0; done = 0;
    in_valid = 0; in_sof = 0; in_eol = 0; in_pix = '0; in_fg = 0; thr_in = '0;
    m_in_frame = 0; m_line = 0; m_cnt = 0; m_thr = 0; stat_due = 0;
    stat_cnt_e = 0; stat_pass_e = 0;
    outstanding = 0; out_pos = 0; beats_seen = 0; pulses_seen = 0;
    void'($urandom(SEED));
    wait (rst_n === 1'b1);
    step();
    chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    chk(stat_valid == 1'b0, "R1 reset stat_valid", int'(stat_valid), 0);

    // R7: beats with no open frame
    b0 = beats_seen; p0 = pulses_seen;
    for (int i = 0; i < 2 * LP; i++) drive(0, (i % LP) == LP - 1, i, 1);
    idle(40);
    chk(beats_seen == b0, "R7 stray beats produced output", beats_seen - b0, 0);
    chk(pulses_seen == p0, "R7 stray beats produced status", pulses_seen - p0, 0);

    // R3 boundaries
    directed(10, 10);
    directed(10, 11);
    directed(0, 0);
    directed(0, 1);
    directed(31, 32);
    directed(32, 32);

    // R4: threshold changes after the start beat
    send_frame(20, 15, 0, 1, 0);
    idle(90);
    send_frame(0, 5, 0, 1, 31);
    idle(90);

    // R8: restart in mid-frame
    p0 = pulses_seen;
    thr_in = CW'(0);
    for (int i = 0; i < 12; i++) drive(i == 0, (i % LP) == LP - 1, i, 1);
    send_frame(4, 4, 0, 0, -1);
    idle(90);
    chk(pulses_seen == p0 + 1, "R8 restarted frame status count", pulses_seen - p0, 1);

    // back-to-back passing frames: stall behaviour (R9 / R10)
    for (int f = 0; f < 3; f++) send_frame(0, 20, 0, 0, -1);
    idle(10);

    // random frames
    for (int f = 0; f < 40; f++) begin
      send_frame(int'($urandom % (DEPTH + 1)), int'($urandom % 100), 1, ($urandom % 2) == 1,
                 (($urandom % 3) == 0) ? int'($urandom % (DEPTH + 1)) : -1);
      if ($urandom % 3 == 0) idle(int'($urandom % 20));
    end

    guard = 0;
    in_valid = 0;
    while ((exp_q.size() > 0 || outstanding > 0) && guard < 2000) begin
      step();
      guard++;
    end
    idle(5);
    chk(exp_q.size() == 0, "R5 forwarded frames fully drained", exp_q.size(), 0);
    done = 1;
  end

endmodule

// File: tb/motion_frame_gate_bench.sv
module motion_frame_gate_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   c_sgl, e_sgl, c_dbl, e_dbl;
  logic d_sgl, d_dbl;

  always #2ns clk = ~clk;

  motion_frame_gate_harness #(.NBUF(1), .SEED(32'd1357)) u_single (
    .clk(clk), .rst_n(rst_n), .n_checks(c_sgl), .n_errors(e_sgl), .done(d_sgl));

  motion_frame_gate_harness #(.NBUF(2), .SEED(32'd2468)) u_double (
    .clk(clk), .rst_n(rst_n), .n_checks(c_dbl), .n_errors(e_dbl), .done(d_dbl));

  initial begin
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
  end

  initial begin
    int timeout;
    timeout = 0;
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (d_sgl === 1'b1 && d_dbl === 1'b1) break;
    end
    if (!(d_sgl === 1'b1 && d_dbl === 1'b1)) begin
      timeout = 1;
      $display("FAIL watchdog: run incomplete, actual 0 expected 1");
    end
    $display("CHECKS %0d ERRORS %0d", c_sgl + c_dbl + timeout, e_sgl + e_dbl + timeout);
    $finish;
  end

endmodule